// File: doc/BRIEF.md
# Watchdog Timer with Programmable Reset Pulse

The block is a watchdog with a small register bus. Software picks two timeout selections, one for the first enable and one for every later reload, and then sets the enable bit. From then on a down-counter runs on every clock. Software keeps it from reaching zero by writing a key byte to a restart register. If the counter does reach zero, the block responds in one of two ways, chosen by a mode bit. In direct mode, it fires a reset pulse at once. In warning mode, the first zero raises an interrupt and reloads the counter. A second zero, with no restart in between, fires the reset pulse.

The reset pulse length comes from a three-bit code: code n gives 2^(n+1) clock cycles. After a write of 1, the enable cannot be cleared by software; only the block's own reset clears it. The reset output is meant to drive the system reset, and the block keeps counting while the pulse is high. Read data appears on the bus one cycle after the read strobe.

Top module: `wdt_watchdog`

## Requirements
- R1: After reset, the control register at offset 0x00 reads 0x08: enable bit 0 is 0, mode bit 1 is 0, and the pulse code in bits [4:2] is 010. The registers at 0x04, 0x08 and 0x10 read 0, and both outputs are low. The pulse code keeps its value across control writes that carry the same code.
- R2: Read data is registered and appears one cycle after the read strobe. Offset 0x04 reads back the run-time selection in bits [3:0] and the first-enable selection in bits [7:4]. Any offset outside 0x00–0x14 reads 0.
- R3: Writing 1 to control bit 0 while the watchdog is disabled loads the counter with 2^(8+s)−1, where s is the first-enable selection. While enabled, the counter decreases by one each cycle, and offset 0x08 returns its value.
- R4: When the enabled counter is 0, an expiry occurs and the counter reloads with 2^(8+r)−1, where r is the run-time selection. The first expiry therefore comes 2^(8+s) cycles after the enabling write, and each later one 2^(8+r) cycles after the previous one.
- R5: A write of 0x76 in the low byte of offset 0x0C, while the watchdog is enabled, reloads the counter with 2^(8+r)−1. Any other value is ignored. The same write while the watchdog is disabled is also ignored and leaves the counter at its value.
- R6: Once set, enable bit 0 stays set; writes of 0 to it have no effect.
- R7: In direct mode (bit 1 = 0), each expiry starts a reset pulse in the following cycle. The pulse lasts 2^(n+1) cycles for pulse code n, and the interrupt output stays low.
- R8: In warning mode (bit 1 = 1), the first expiry sets status bit 0 at offset 0x10 and the interrupt output, with no pulse. A second expiry with no key write in between starts the reset pulse. A key write returns the block to the first stage.
- R9: A read of offset 0x14 returns the status bit and clears it and the interrupt output. Writes to offset 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Warning interrupt, level |
| rst_pulse_o | output | 1 | System reset pulse, active high |

## Verification
The bench predicts the exact cycle each reset pulse starts and how long it lasts. A design that reloads with the wrong selection on the first enable, or that honours a wrong key, shifts a pulse and fails the timing comparison. An unexpected pulse is also reported: in warning mode on the first expiry, or after a key write that should have reset the stage. Each pulse code is measured on its own; an off-by-one in the pulse counter gives a pulse one cycle long or short. The bench also targets the sticky enable bit, a clear-on-read that must return the status before clearing it, and key writes made while the watchdog is disabled; a design that lets any of these through changes the read-back values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_RANGE = 'h04;
  localparam int unsigned OFS_COUNT = 'h08;
  localparam int unsigned OFS_KICK  = 'h0C;
  localparam int unsigned OFS_ISTAT = 'h10;
  localparam int unsigned OFS_ICLR  = 'h14;

  localparam logic [7:0] KICK_KEY = 8'h76;
  localparam int unsigned PLEN_RST = 2;

  typedef enum logic {STG_WARN, STG_BITE} stage_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TSEL_W = 4,
  parameter int PLEN_W = 3,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              en_o,
  output logic              mode_o,
  output logic [PLEN_W-1:0] plen_o,
  output logic [TSEL_W-1:0] run_sel_o,
  output logic [TSEL_W-1:0] init_sel_o,
  output logic              en_rise_o,
  output logic              kick_o,
  output logic              iclr_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              istat_i
);
  localparam int INIT_LSB = (TSEL_W > 4) ? TSEL_W : 4;

  logic              en_q, mode_q;
  logic [PLEN_W-1:0] plen_q;
  logic [TSEL_W-1:0] run_q, init_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  logic wr_ctrl, wr_range, wr_kick;
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_range = bus_wr && (bus_addr == ADDR_W'(OFS_RANGE));
  assign wr_kick  = bus_wr && (bus_addr == ADDR_W'(OFS_KICK));

  // Named events for the counter and the assertions
  assign en_rise_o = wr_ctrl && bus_wdata[0] && !en_q;
  assign kick_o    = wr_kick && (bus_wdata[7:0] == KICK_KEY) && en_q;
  assign iclr_o    = bus_rd && (bus_addr == ADDR_W'(OFS_ICLR));

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      plen_q <= PLEN_W'(PLEN_RST);
      run_q  <= '0;
      init_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= en_q | bus_wdata[0];
        mode_q <= bus_wdata[1];
        plen_q <= bus_wdata[2 +: PLEN_W];
      end
      if (wr_range) begin
        run_q  <= bus_wdata[0 +: TSEL_W];
        init_q <= bus_wdata[INIT_LSB +: TSEL_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): begin
        rd_mux[0]            = en_q;
        rd_mux[1]            = mode_q;
        rd_mux[2 +: PLEN_W]  = plen_q;
      end
      ADDR_W'(OFS_RANGE): begin
        rd_mux[0 +: TSEL_W]        = run_q;
        rd_mux[INIT_LSB +: TSEL_W] = init_q;
      end
      ADDR_W'(OFS_COUNT): rd_mux = DATA_W'(cnt_i);
      ADDR_W'(OFS_ISTAT): rd_mux[0] = istat_i;
      ADDR_W'(OFS_ICLR):  rd_mux[0] = istat_i;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata  = rdata_q;
  assign en_o       = en_q;
  assign mode_o     = mode_q;
  assign plen_o     = plen_q;
  assign run_sel_o  = run_q;
  assign init_sel_o = init_q;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) en_q |=> en_q);  // R6
  AST_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));  // R2
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int TSEL_W   = 4,
  parameter int BASE_EXP = 8,
  parameter int CNT_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [TSEL_W-1:0] run_sel_i,
  input  logic [TSEL_W-1:0] init_sel_i,
  input  logic              en_rise_i,
  input  logic              kick_i,
  input  logic              iclr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              istat_o,
  output logic              expire_o,
  output logic              bite_o
);
  function automatic logic [CNT_W-1:0] reload_for(input logic [TSEL_W-1:0] sel);
    return (CNT_W'(1) << (BASE_EXP + int'(sel))) - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  stage_t           stage_q;
  logic             istat_q;
  logic             warn;

  // A key write in the same cycle wins over an expiry
  assign expire_o = en_i && (cnt_q == '0) && !kick_i;
  assign bite_o   = expire_o && (!mode_i || (stage_q == STG_BITE));
  assign warn     = expire_o && mode_i && (stage_q == STG_WARN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_rise_i) begin
      cnt_q <= reload_for(init_sel_i);
    end else if (kick_i || expire_o) begin
      cnt_q <= reload_for(run_sel_i);
    end else if (en_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_WARN;
      istat_q <= 1'b0;
    end else begin
      if (kick_i)      stage_q <= STG_WARN;
      else if (warn)   stage_q <= STG_BITE;
      else if (bite_o) stage_q <= STG_WARN;
      if (warn)        istat_q <= 1'b1;
      else if (iclr_i) istat_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign istat_o = istat_q;

  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !kick_i && !en_rise_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));  // R3
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !en_rise_i) |=> $stable(cnt_q));  // R5
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == reload_for($past(run_sel_i))));  // R5
  AST_EXPIRY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == reload_for($past(run_sel_i))));  // R4
  AST_IRQ_FROM_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(istat_q) |-> $past(expire_o && mode_i));  // R8
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PLEN_W = 3,
  parameter int PCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PLEN_W-1:0] plen_i,
  output logic              pulse_o
);
  function automatic logic [PCNT_W-1:0] pulse_cycles(input logic [PLEN_W-1:0] code);
    return PCNT_W'(1) << (int'(code) + 1);
  endfunction

  logic              active_q;
  logic [PCNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      left_q   <= pulse_cycles(plen_i) - PCNT_W'(1);
    end else if (active_q) begin
      if (left_q == '0) active_q <= 1'b0;
      else              left_q   <= left_q - PCNT_W'(1);
    end
  end

  assign pulse_o = active_q;

  AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(start_i));  // R7
  AST_PULSE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && left_q != '0) |=> active_q);  // R7
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && left_q == '0 && !start_i) |=> !active_q);  // R7
endmodule

// File: rtl/wdt_watchdog.sv
module wdt_watchdog #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TSEL_W   = 4,
  parameter int PLEN_W   = 3,
  parameter int BASE_EXP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_pulse_o
);
  localparam int CNT_W  = BASE_EXP + (1 << TSEL_W);
  localparam int PCNT_W = (1 << PLEN_W) + 1;

  logic              en, mode, en_rise, kick, iclr, istat, expire, bite;
  logic [PLEN_W-1:0] plen;
  logic [TSEL_W-1:0] run_sel, init_sel;
  logic [CNT_W-1:0]  cnt;

  wdt_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TSEL_W(TSEL_W), .PLEN_W(PLEN_W), .CNT_W(CNT_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en_o(en), .mode_o(mode), .plen_o(plen), .run_sel_o(run_sel),
    .init_sel_o(init_sel), .en_rise_o(en_rise), .kick_o(kick), .iclr_o(iclr),
    .cnt_i(cnt), .istat_i(istat)
  );

  wdt_countdown #(
    .TSEL_W(TSEL_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)
  ) i_count (
    .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .run_sel_i(run_sel),
    .init_sel_i(init_sel), .en_rise_i(en_rise), .kick_i(kick), .iclr_i(iclr),
    .cnt_o(cnt), .istat_o(istat), .expire_o(expire), .bite_o(bite)
  );

  wdt_pulse_gen #(
    .PLEN_W(PLEN_W), .PCNT_W(PCNT_W)
  ) i_pulse (
    .clk(clk), .rst_n(rst_n), .start_i(bite), .plen_i(plen), .pulse_o(rst_pulse_o)
  );

  assign irq_o = istat;

  AST_DIRECT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode) |=> $stable(irq_o));  // R7
  AST_BITE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> rst_pulse_o);  // R7
endmodule

// File: tb/test_wdt_watchdog.sv
`timescale 1ns/1ps
module test_wdt_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_pulse_o;

  always #4 clk = ~clk;

  wdt_watchdog i_wdt_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_pulse_o(rst_pulse_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  int wcyc = 0, rcyc = 0;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Scoreboard of expected reset pulses
  typedef struct { string tag; int rise; int len; } pexp_t;
  pexp_t sb[$];

  task automatic expect_pulse(input string tag, input int rise, input int len);
    pexp_t e;
    e.tag = tag; e.rise = rise; e.len = len;
    sb.push_back(e);
  endtask

  int run_len = 0, rise_at = 0;
  logic prev = 1'b0;
  always @(negedge clk) begin
    if (rst_pulse_o && !prev) begin
      rise_at = cyc; run_len = 1;
    end else if (rst_pulse_o) begin
      run_len++;
    end else if (prev) begin
      if (sb.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R8: unexpected pulse at cycle %0d length %0d, expected none", rise_at, run_len);
      end else begin
        pexp_t e;
        e = sb.pop_front();
        check({e.tag, " pulse start"}, rise_at, e.rise);
        check({e.tag, " pulse length"}, run_len, e.len);
      end
    end
    prev = rst_pulse_o;
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    wcyc = cyc;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    rcyc = cyc;
    d = bus_rdata;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'h00, d); check("R1 ctrl", d, 32'h08);
    bus_read(8'h04, d); check("R1 range", d, 0);
    bus_read(8'h08, d); check("R1 count", d, 0);
    bus_read(8'h10, d); check("R1 status", d, 0);
    check("R1 irq", irq_o, 0);
    check("R1 pulse", rst_pulse_o, 0);

    // R5 key while disabled, R9 status not writable, R2 map
    bus_write(8'h0C, 32'h76);
    bus_read(8'h08, d); check("R5 key while disabled", d, 0);
    bus_write(8'h10, 32'h1);
    bus_read(8'h10, d); check("R9 status write ignored", d, 0);
    bus_write(8'h04, 32'h53);
    bus_read(8'h04, d); check("R2 range readback", d, 32'h53);
    bus_read(8'h18, d); check("R2 unmapped", d, 0);

    // Direct mode, code 010, first 256 then 512 cycles
    do_reset();
    bus_write(8'h04, 32'h01);
    bus_write(8'h00, 32'h09);
    w = wcyc;
    expect_pulse("R4 first", w + 256, 8);
    expect_pulse("R4 later", w + 768, 8);
    repeat (20) @(negedge clk);
    bus_read(8'h08, d); check("R3 count", d, 256 - (rcyc - w));
    bus_read(8'h00, d); check("R1 code kept", d, 32'h09);
    bus_write(8'h00, 32'h08);
    bus_read(8'h00, d); check("R6 enable sticky", d, 32'h09);
    bus_write(8'h0C, 32'h75);
    wait_until(w + 790);
    check("R4 pulses seen", sb.size(), 0);
    check("R7 no irq", irq_o, 0);
    bus_read(8'h10, d); check("R7 status clear", d, 0);
    do_reset();

    // Key write reload, init 512 run 256, code 000
    bus_write(8'h04, 32'h10);
    bus_write(8'h00, 32'h01);
    w = wcyc;
    wait_until(w + 400);
    bus_write(8'h0C, 32'h76);
    k = wcyc;
    expect_pulse("R5 after key", k + 256, 2);
    expect_pulse("R4 run reload", k + 512, 2);
    repeat (10) @(negedge clk);
    bus_read(8'h08, d); check("R5 count after key", d, 256 - (rcyc - k));
    wait_until(k + 530);
    check("R5 pulses seen", sb.size(), 0);
    do_reset();

    // Pulse code 011 and 111
    bus_write(8'h04, 32'h00);
    bus_write(8'h00, 32'h0D);
    w = wcyc;
    expect_pulse("R7 code3", w + 256, 16);
    wait_until(w + 290);
    check("R7 code3 seen", sb.size(), 0);
    do_reset();
    bus_write(8'h04, 32'h11);
    bus_write(8'h00, 32'h1D);
    w = wcyc;
    expect_pulse("R7 code7", w + 512, 256);
    wait_until(w + 790);
    check("R7 code7 seen", sb.size(), 0);
    do_reset();

    // Warning mode, two expiries
    bus_write(8'h04, 32'h00);
    bus_write(8'h00, 32'h0B);
    w = wcyc;
    expect_pulse("R8 second expiry", w + 512, 8);
    wait_until(w + 255); check("R8 irq before", irq_o, 0);
    wait_until(w + 256); check("R8 irq after", irq_o, 1);
    wait_until(w + 300);
    bus_read(8'h10, d); check("R8 status", d, 1);
    bus_read(8'h14, d); check("R9 clear returns", d, 1);
    check("R9 irq cleared", irq_o, 0);
    bus_read(8'h10, d); check("R9 status cleared", d, 0);
    wait_until(w + 530);
    check("R8 pulse seen", sb.size(), 0);
    do_reset();

    // Warning mode, key write returns to first stage
    bus_write(8'h04, 32'h00);
    bus_write(8'h00, 32'h0B);
    w = wcyc;
    wait_until(w + 260);
    bus_read(8'h14, d); check("R9 clear", d, 1);
    bus_write(8'h0C, 32'h76);
    k = wcyc;
    expect_pulse("R8 after key", k + 512, 8);
    wait_until(k + 255); check("R8 irq low", irq_o, 0);
    wait_until(k + 256); check("R8 warn again", irq_o, 1);
    wait_until(k + 530);
    check("R8 key pulses seen", sb.size(), 0);
    do_reset();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule